// File: doc/BRIEF.md
# E1 Timeslot-Zero Receive Extractor

This block sits after a frame and multiframe aligner on the receive side of an E1 line. Each aligned timeslot-zero word arrives with a one-cycle strobe and its frame number within the CRC-4 multiframe (0 to 15). Only the odd frames carry the non-frame-alignment word. From those frames the block takes the five national bits Sa4 to Sa8. It gathers each bit position across the eight odd frames of one multiframe into its own byte. The bytes go into a shadow store, and the whole set is copied to readable registers when the multiframe closes.

The close of every multiframe raises a sticky status flag. The flag also drives an interrupt that software can mask. A small register port reads the five bytes and the flag, and reading the flag clears it. In parallel, one Sa position, chosen by a one-hot select, is sent out as a 4 kbit/s serial data link. Its 4 kHz clock is generated locally and runs free. A frame slip can therefore drop or repeat one data bit, but it never moves the clock edges.

Top module: `e1_ts0_rx_extract`

## Requirements
- R1: After reset, rd_data_o, mf_status_o, irq_o, dl_clk_o and dl_data_o are all 0, and every Sa byte reads as 0.
- R2: Words whose frame number is even change neither the Sa bytes nor the data link.
- R3: Byte address k (0 to 4) holds Sa(4+k). Sa(4+k) is bit 4-k of ts0_data_i, where bit 7 is the first bit on the line. The odd frame 2j+1 fills bit 7-j of each byte, so frame 1 lands in the MSB.
- R4: The readable bytes change only in the cycle after a word with frame number 15 is accepted. Until then, reads return the previous multiframe's bytes.
- R5: mf_status_o goes to 1 in the cycle after a frame-15 word is accepted and stays at 1. A read of address 5 returns the flag in bit 0 and clears it; a new event in the same cycle wins over the clear.
- R6: irq_o equals mf_status_o ANDed with irq_mask_i.
- R7: rd_data_o loads the addressed register in the cycle after rd_en_i and holds its value otherwise. Addresses 6 and 7 read as 0.
- R8: The data link bit comes from the Sa position whose bit is set in dl_sel_i (bit 0 selects Sa4, bit 4 selects Sa8), taken only from odd frames.
- R9: dl_clk_o runs freely from reset, with DL_HALF cycles high and DL_HALF cycles low, whatever the input traffic.
- R10: dl_data_o changes only at a falling edge of dl_clk_o. It then takes the most recent link bit received before that edge. If two bits arrive between falling edges, the earlier one is lost; if none arrives, the previous bit is repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ts0_valid_i | input | 1 | Strobe for an aligned timeslot-zero word |
| ts0_data_i | input | 8 | Timeslot-zero word, bit 7 first on the line |
| frame_num_i | input | 4 | Frame number within the CRC-4 multiframe |
| dl_sel_i | input | 5 | One-hot Sa select for the data link |
| irq_mask_i | input | 1 | Interrupt enable |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | 3 | Read address: 0-4 Sa bytes, 5 status |
| rd_data_o | output | 8 | Registered read data |
| mf_status_o | output | 1 | Sticky multiframe-start flag |
| irq_o | output | 1 | Masked interrupt |
| dl_clk_o | output | 1 | Free-running 4 kHz data link clock |
| dl_data_o | output | 1 | Data link output, changes at falling edges |

## Verification
Several multiframe patterns are driven, and in each one the even-frame words are the complement of the odd ones. Reading the wrong frames, or reading the wrong bit slot, therefore shows up directly in the bytes. Each pattern is built so that each Sa position and each frame slot carries a different bit. This tells apart swapped bytes, bit orders running the wrong way, and a copy that happens too early, which a mid-multiframe read exposes.

On the data link, the driven words set either only the selected bit or every bit except the selected one, so a select that picks the wrong position gives the wrong level. Two bits are sent between falling edges to show that the first is lost, and a period with no bit shows that the last one repeats. The clock edges are counted throughout to confirm the period never changes.

// File: rtl/e1_ts0_pkg.sv
package e1_ts0_pkg;
  localparam int TS_W      = 8;
  localparam int SA_NUM    = 5;
  localparam int SA_FIRST  = 4;                    // line bit number of first Sa
  localparam int MF_FRAMES = 16;
  localparam int FN_W      = $clog2(MF_FRAMES);
  localparam int SLOTS     = MF_FRAMES / 2;        // odd frames per multiframe
  localparam int SLOT_W    = FN_W - 1;
  localparam int ADDR_W    = 3;
  localparam int STAT_ADDR = SA_NUM;

  typedef logic [TS_W-1:0]  sa_byte_t;
  typedef logic [SA_NUM-1:0] sa_vec_t;
endpackage

// File: rtl/e1_sa_capture.sv
module e1_sa_capture
  import e1_ts0_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  logic [FN_W-1:0]       frame_i,
  input  sa_vec_t               sa_i,
  input  logic                  stat_clr_i,
  output sa_byte_t [SA_NUM-1:0] bytes_o,
  output logic                  status_o
);
  sa_byte_t [SA_NUM-1:0] shadow_q, shadow_d, bytes_q;
  logic                  status_q;
  logic                  odd_w, mf_evt;
  logic [SLOT_W-1:0]     bit_pos;

  assign odd_w   = valid_i && frame_i[0];
  assign mf_evt  = valid_i && (frame_i == FN_W'(MF_FRAMES-1));
  assign bit_pos = SLOT_W'(SLOTS-1) - frame_i[FN_W-1:1];

  for (genvar k = 0; k < SA_NUM; k++) begin : g_sa
    always_comb begin
      shadow_d[k] = shadow_q[k];
      if (odd_w) shadow_d[k][bit_pos] = sa_i[k];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      bytes_q  <= '0;
      status_q <= 1'b0;
    end else begin
      shadow_q <= shadow_d;
      if (mf_evt) bytes_q <= shadow_d;
      if (mf_evt) status_q <= 1'b1;
      else if (stat_clr_i) status_q <= 1'b0;
    end
  end

  assign bytes_o  = bytes_q;
  assign status_o = status_q;

  assert_bytes_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mf_evt |=> $stable(bytes_q));
  assert_status_src_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_q) |-> $past(valid_i && frame_i == FN_W'(MF_FRAMES-1)));
  assert_status_clr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_clr_i && !mf_evt) |=> !status_q);
endmodule

// File: rtl/e1_dl_extract.sv
module e1_dl_extract
  import e1_ts0_pkg::*;
#(
  parameter int DL_HALF = 1000
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    valid_i,
  input  logic    odd_i,
  input  sa_vec_t sa_i,
  input  sa_vec_t sel_i,
  output logic    dl_clk_o,
  output logic    dl_data_o
);
  localparam int CNT_W = (DL_HALF > 1) ? $clog2(DL_HALF) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic             clk_q, hold_q, data_q;
  logic             wrap, fall;

  assign wrap = (cnt_q == CNT_W'(DL_HALF-1));
  assign fall = wrap && clk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      clk_q  <= 1'b0;
      hold_q <= 1'b0;
      data_q <= 1'b0;
    end else begin
      cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      if (wrap) clk_q <= ~clk_q;
      if (valid_i && odd_i) hold_q <= |(sa_i & sel_i);  // latest bit wins on slip
      if (fall) data_q <= hold_q;
    end
  end

  assign dl_clk_o  = clk_q;
  assign dl_data_o = data_q;

  assert_data_on_fall_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(data_q) |-> $fell(clk_q));
  assert_sel_onehot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_i));
  assert_clk_edges_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(clk_q) |-> $past(wrap));
endmodule

// File: rtl/e1_ts0_rx_extract.sv
module e1_ts0_rx_extract
  import e1_ts0_pkg::*;
#(
  parameter int DL_HALF = 1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ts0_valid_i,
  input  logic [TS_W-1:0]   ts0_data_i,
  input  logic [FN_W-1:0]   frame_num_i,
  input  logic [SA_NUM-1:0] dl_sel_i,
  input  logic              irq_mask_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [TS_W-1:0]   rd_data_o,
  output logic              mf_status_o,
  output logic              irq_o,
  output logic              dl_clk_o,
  output logic              dl_data_o
);
  sa_vec_t               sa_vec;
  sa_byte_t [SA_NUM-1:0] bytes;
  sa_byte_t              rd_mux, rd_q;
  logic                  status, stat_clr;
  logic                  unused_align;

  assign unused_align = ^ts0_data_i[TS_W-1:SA_FIRST+1];

  // line bit n sits at ts0_data_i[TS_W-n]
  for (genvar k = 0; k < SA_NUM; k++) begin : g_sa_map
    assign sa_vec[k] = ts0_data_i[TS_W - (SA_FIRST + k)];
  end

  assign stat_clr = rd_en_i && (rd_addr_i == ADDR_W'(STAT_ADDR));

  e1_sa_capture u_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (ts0_valid_i),
    .frame_i    (frame_num_i),
    .sa_i       (sa_vec),
    .stat_clr_i (stat_clr),
    .bytes_o    (bytes),
    .status_o   (status)
  );

  e1_dl_extract #(.DL_HALF(DL_HALF)) u_dl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (ts0_valid_i),
    .odd_i     (frame_num_i[0]),
    .sa_i      (sa_vec),
    .sel_i     (dl_sel_i),
    .dl_clk_o  (dl_clk_o),
    .dl_data_o (dl_data_o)
  );

  always_comb begin
    rd_mux = '0;
    for (int k = 0; k < SA_NUM; k++)
      if (rd_addr_i == ADDR_W'(k)) rd_mux = bytes[k];
    if (rd_addr_i == ADDR_W'(STAT_ADDR)) rd_mux = {{(TS_W-1){1'b0}}, status};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_q <= '0;
    else if (rd_en_i) rd_q <= rd_mux;
  end

  assign rd_data_o   = rd_q;
  assign mf_status_o = status;
  assign irq_o       = status & irq_mask_i;

  assert_rd_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));
endmodule

// File: tb/e1_ts0_rx_extract_tb.sv
`timescale 1ns/1ps
module e1_ts0_rx_extract_tb;
  localparam int HALF = 8;
  localparam int NPAT = 5;
  localparam logic [15:0] PAT [NPAT] = '{16'hA53C, 16'h00FF, 16'hFF01, 16'h1235, 16'hC3E7};

  logic       clk = 0, rst_n = 0;
  logic       valid = 0, mask = 0, rd_en = 0;
  logic [7:0] data = 0;
  logic [3:0] fnum = 0;
  logic [4:0] sel = 5'b00001;
  logic [2:0] addr = 0;
  logic [7:0] rd_data;
  logic       mf_st, irq, dl_clk, dl_data;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  e1_ts0_rx_extract #(.DL_HALF(HALF)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ts0_valid_i(valid), .ts0_data_i(data),
    .frame_num_i(fnum), .dl_sel_i(sel), .irq_mask_i(mask), .rd_en_i(rd_en),
    .rd_addr_i(addr), .rd_data_o(rd_data), .mf_status_o(mf_st), .irq_o(irq),
    .dl_clk_o(dl_clk), .dl_data_o(dl_data));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [3:0] f, input logic [7:0] d);
    @(negedge clk); valid = 1; fnum = f; data = d;
    @(negedge clk); valid = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; v = rd_data;
  endtask

  task automatic wait_fall();
    while (dl_clk !== 1'b1) @(negedge clk);
    while (dl_clk !== 1'b0) @(negedge clk);
  endtask

  function automatic logic [7:0] word_of(input logic [15:0] p, input int f);
    logic [7:0] m;
    m = p[7:0] * 8'(f + 3);
    return p[15:8] ^ m ^ 8'(f * 37);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v, w;
    logic [7:0] exp_b [5];
    logic [7:0] prev0;
    int t0, n;

    repeat (3) @(negedge clk);
    chk(rd_data == 0 && mf_st == 0 && irq == 0 && dl_clk == 0 && dl_data == 0,
        "R1 reset outputs", {rd_data, mf_st, irq, dl_clk, dl_data}, 0);
    rst_n = 1;
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v); chk(v == 0, "R1 reset byte", v, 0);
    end

    // table walk: one multiframe per pattern, even words are complements
    prev0 = 0;
    for (int i = 0; i < NPAT; i++) begin
      mask = i[0];
      for (int k = 0; k < 5; k++) exp_b[k] = 0;
      for (int j = 0; j < 8; j++) begin
        w = word_of(PAT[i], 2*j+1);
        for (int k = 0; k < 5; k++) exp_b[k][7-j] = w[4-k];
      end
      for (int f = 0; f < 15; f++)
        send(4'(f), f[0] ? word_of(PAT[i], f) : ~word_of(PAT[i], f+1));
      chk(mf_st == 0, "R5 no flag mid multiframe", mf_st, 0);
      rd(3'd0, v); chk(v == prev0, "R4 old bytes before frame 15", v, prev0);
      send(4'd15, word_of(PAT[i], 15));
      chk(mf_st == 1, "R5 flag after frame 15", mf_st, 1);
      chk(irq == mask, "R6 irq follows mask", irq, mask);
      for (int k = 0; k < 5; k++) begin
        rd(3'(k), v); chk(v == exp_b[k], "R2 R3 Sa byte", v, exp_b[k]);
      end
      chk(mf_st == 1, "R5 flag sticky", mf_st, 1);
      rd(3'd5, v); chk(v == 8'h01, "R5 status read", v, 1);
      chk(mf_st == 0 && irq == 0, "R5 R6 cleared by read", {mf_st, irq}, 0);
      rd(3'd5, v); chk(v == 8'h00, "R5 status reads 0 after clear", v, 0);
      prev0 = exp_b[0];
    end

    // R7: unused addresses, hold without read
    rd(3'd6, v); chk(v == 0, "R7 addr 6", v, 0);
    rd(3'd7, v); chk(v == 0, "R7 addr 7", v, 0);
    repeat (4) @(negedge clk);
    chk(rd_data == 0, "R7 hold without rd_en", rd_data, 0);

    // R9: clock phases
    while (dl_clk !== 1) @(negedge clk);
    n = 0; while (dl_clk === 1) begin n++; @(negedge clk); end
    chk(n == HALF, "R9 high phase", n, HALF);
    n = 0; while (dl_clk === 0) begin n++; @(negedge clk); end
    chk(n == HALF, "R9 low phase", n, HALF);

    // R8: select Sa6 (line bit 6 = data[2])
    sel = 5'b00100;
    send(4'd1, 8'h04); wait_fall();
    chk(dl_data == 1, "R8 Sa6 one", dl_data, 1);
    send(4'd3, 8'hFB); wait_fall();
    chk(dl_data == 0, "R8 Sa6 zero others set", dl_data, 0);
    send(4'd2, 8'hFF); wait_fall();
    chk(dl_data == 0, "R2 R8 even frame ignored by link", dl_data, 0);
    sel = 5'b10000;
    send(4'd5, 8'h01); wait_fall();
    chk(dl_data == 1, "R8 Sa8 one", dl_data, 1);

    // R10: slip cases, and R9 phase unchanged through them
    wait_fall(); t0 = $time;
    send(4'd7, 8'h00); send(4'd9, 8'h01); wait_fall();
    chk(dl_data == 1, "R10 two bits keep latest", dl_data, 1);
    send(4'd11, 8'h01); send(4'd13, 8'h00); wait_fall();
    chk(dl_data == 0, "R10 earlier bit lost", dl_data, 0);
    wait_fall();
    chk(dl_data == 0, "R10 no bit repeats", dl_data, 0);
    n = ($time - t0) / 5;
    chk(n % (2*HALF) == 0, "R9 phase kept across slips", n % (2*HALF), 0);
    // R10: data steady between falling edges
    send(4'd1, 8'h01);
    while (dl_clk !== 1) @(negedge clk);
    chk(dl_data == 0, "R10 no change before fall", dl_data, 0);
    while (dl_clk !== 0) @(negedge clk);
    chk(dl_data == 1, "R10 change at fall", dl_data, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule